// File: doc/BRIEF.md
# Invariant Time-Stamp Counter

This block keeps a free-running 64-bit tick count for a processor core and lets software sample it. After reset the count starts at zero and climbs with no further attention. Two increment modes are offered. In per-cycle mode the count adds one on every core clock edge, so its rate tracks whatever core-to-bus ratio is in force. In constant-rate mode the count adds a programmable step only on cycles where a fixed reference enable pulses, so each tick lasts the same wall-clock time however the core frequency moves.

A halted core and an asserted stop-clock request leave the count running. Only the deep-sleep indication freezes it. Software reads go through a request strobe. A permit flag in the control word decides whether a read returns the full count, captured in one cycle, or raises a one-cycle fault. A constant capability word reports that the counter exists.

Top module: `tscTop`

## Requirements
- R1: While rstN is low and on the first cycle after it rises, count is zero and rdValid and rdFault are low.
- R2: With deepSleep low and modeConst low, count rises by exactly one at every rising clock edge. refTick and stepInc have no effect in this mode.
- R3: With deepSleep low and modeConst high, count rises by the zero-extended stepInc at each edge where refTick is high, and holds at each edge where refTick is low.
- R4: coreHalt and stopClk have no effect on count or on the read path.
- R5: While deepSleep is high, count holds its value in both modes.
- R6: capWord is constant with bit 4 set to 1 and every other bit 0 (value 0x10).
- R7: A request (rdReq high) while ctrlWord bit 2 is 1 gives rdValid high and rdFault low on the next cycle. rdData then equals the full count that was visible in the request cycle.
- R8: A request while ctrlWord bit 2 is 0 gives rdFault high and rdValid low on the next cycle, for one cycle only, and leaves rdData unchanged. The other ctrlWord bits are ignored. With no request, rdValid and rdFault are low on the next cycle.
- R9: A count of all ones goes to zero at the next increment of one, and counting then continues normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeConst | input | 1 | 1 selects constant-rate mode, 0 selects per-cycle mode |
| refTick | input | 1 | Fixed-rate reference enable, sampled at each clock edge |
| stepInc | input | STEP_W (16) | Amount added per reference pulse in constant-rate mode |
| coreHalt | input | 1 | Core halted indication (does not stop counting) |
| stopClk | input | 1 | External stop-clock indication (does not stop counting) |
| deepSleep | input | 1 | Deep-sleep indication; freezes the count |
| ctrlWord | input | 8 | Control word; bit 2 = 1 permits software reads |
| rdReq | input | 1 | Software read request strobe |
| count | output | CNT_W (64) | Live counter value |
| rdData | output | CNT_W (64) | Count captured by the last permitted read |
| rdValid | output | 1 | rdData updated this cycle |
| rdFault | output | 1 | Last request was refused |
| capWord | output | 32 | Capability word, bit 4 = counter present |

## Verification
A wrong step value or mode decode changes the count at the very next edge, because count is a port compared against the bench model every cycle. A frozen or run-away counter shows within one cycle in the same way. A capture register loaded from the wrong cycle, or loaded during a refused read, shows as a rdData mismatch one cycle after the request. A stuck or lengthened fault pulse shows on the cycle after it. The carry path across the full width is exercised by a narrowed instance that wraps within a few thousand cycles.

// File: rtl/tscPkg.sv
package tscPkg;
  // Strobes that the control half hands to the datapath for one cycle.
  typedef struct packed {
    logic advance;   // add addend to the count at this edge
    logic useStep;   // addend is the programmed step, not one
    logic capture;   // latch count into the read register
    logic fault;     // refuse the pending read
  } tscStrobes_t;

  localparam int CAP_W         = 32;
  localparam int PRESENT_BIT   = 4;
  localparam int CTRL_W        = 8;
  localparam int READ_PERMIT_BIT = 2;
endpackage

// File: rtl/tscCtrl.sv
module tscCtrl
  import tscPkg::*;
(
  input  logic              modeConst,
  input  logic              refTick,
  input  logic              coreHalt,
  input  logic              stopClk,
  input  logic              deepSleep,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              rdReq,
  output tscStrobes_t       strb
);
  logic readPermit;
  logic unusedCtrl;

  assign readPermit = ctrlWord[READ_PERMIT_BIT];

  // Halt and stop-clock never gate the count; other control bits are spare.
  assign unusedCtrl = ^{coreHalt, stopClk, ctrlWord};

  always_comb begin
    strb         = '0;
    strb.useStep = modeConst;
    if (!deepSleep) begin
      strb.advance = modeConst ? refTick : 1'b1;
    end
    strb.capture = rdReq && readPermit;
    strb.fault   = rdReq && !readPermit;
  end
endmodule

// File: rtl/tscDatapath.sv
module tscDatapath
  import tscPkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tscStrobes_t       strb,
  input  logic [STEP_W-1:0] stepInc,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  rdData,
  output logic              rdValid,
  output logic              rdFault
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] stepExt;
  logic [CNT_W-1:0] addend;
  logic [CNT_W-1:0] cnt;

  generate
    if (STEP_W >= CNT_W) begin : gStepTrim
      assign stepExt = stepInc[CNT_W-1:0];
    end else begin : gStepPad
      assign stepExt = {{(CNT_W-STEP_W){1'b0}}, stepInc};
    end
  endgenerate

  assign addend = strb.useStep ? stepExt : ONE;

  // Single full-width register: a read can never see halves from different edges.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.advance) begin
      cnt <= cnt + addend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      rdFault <= 1'b0;
    end else begin
      rdValid <= strb.capture;
      rdFault <= strb.fault;
      if (strb.capture) begin
        rdData <= cnt;
      end
    end
  end

  assign count = cnt;

  a_r7_capture_whole: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (rdValid && !rdFault && rdData == $past(cnt)));

  a_r8_fault_holds_data: assert property (@(posedge clk) disable iff (!rstN)
    strb.fault |=> (rdFault && !rdValid && $stable(rdData)));

  a_r9_unit_step_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.useStep) |=> (cnt == $past(cnt) + ONE));
endmodule

// File: rtl/tscTop.sv
module tscTop
  import tscPkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeConst,
  input  logic              refTick,
  input  logic [STEP_W-1:0] stepInc,
  input  logic              coreHalt,
  input  logic              stopClk,
  input  logic              deepSleep,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              rdReq,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  rdData,
  output logic              rdValid,
  output logic              rdFault,
  output logic [CAP_W-1:0]  capWord
);
  tscStrobes_t strb;

  assign capWord = CAP_W'(1) << PRESENT_BIT;

  tscCtrl uCtrl (
    .modeConst (modeConst),
    .refTick   (refTick),
    .coreHalt  (coreHalt),
    .stopClk   (stopClk),
    .deepSleep (deepSleep),
    .ctrlWord  (ctrlWord),
    .rdReq     (rdReq),
    .strb      (strb)
  );

  tscDatapath #(.CNT_W(CNT_W), .STEP_W(STEP_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .stepInc (stepInc),
    .count   (count),
    .rdData  (rdData),
    .rdValid (rdValid),
    .rdFault (rdFault)
  );

  a_r5_sleep_freezes: assert property (@(posedge clk) disable iff (!rstN)
    deepSleep |=> $stable(count));

  a_r3_idle_without_ref: assert property (@(posedge clk) disable iff (!rstN)
    (modeConst && !refTick) |=> $stable(count));

  a_r4_halt_keeps_counting: assert property (@(posedge clk) disable iff (!rstN)
    ((coreHalt || stopClk) && !deepSleep && !modeConst) |=> (count == $past(count) + CNT_W'(1)));

  a_r8_no_request_no_response: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> (!rdValid && !rdFault));
endmodule

// File: tb/tscTop_test.sv
module tscTop_test;
  localparam int CNT_W  = 64;
  localparam int STEP_W = 16;
  localparam int NAR_W  = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeConst = 1'b0;
  logic              refTick = 1'b0;
  logic [STEP_W-1:0] stepInc = '0;
  logic              coreHalt = 1'b0;
  logic              stopClk = 1'b0;
  logic              deepSleep = 1'b0;
  logic [7:0]        ctrlWord = 8'h00;
  logic              rdReq = 1'b0;
  logic [CNT_W-1:0]  count, rdData;
  logic              rdValid, rdFault;
  logic [31:0]       capWord;

  logic [NAR_W-1:0]  narCount, narRdData;
  logic              narRdValid, narRdFault;
  logic [31:0]       narCap;

  int errors = 0;
  int checks = 0;
  logic [CNT_W-1:0] expCount = '0;
  logic [CNT_W-1:0] expRdData = '0;

  always #4ns clk = ~clk;  // 125 MHz

  tscTop #(.CNT_W(CNT_W), .STEP_W(STEP_W)) uut (
    .clk(clk), .rstN(rstN), .modeConst(modeConst), .refTick(refTick),
    .stepInc(stepInc), .coreHalt(coreHalt), .stopClk(stopClk),
    .deepSleep(deepSleep), .ctrlWord(ctrlWord), .rdReq(rdReq),
    .count(count), .rdData(rdData), .rdValid(rdValid), .rdFault(rdFault),
    .capWord(capWord)
  );

  // Narrow copy, free-running in per-cycle mode, to reach the wrap point.
  tscTop #(.CNT_W(NAR_W), .STEP_W(STEP_W)) uutNarrow (
    .clk(clk), .rstN(rstN), .modeConst(1'b0), .refTick(1'b0),
    .stepInc('0), .coreHalt(1'b0), .stopClk(1'b0),
    .deepSleep(1'b0), .ctrlWord(8'h04), .rdReq(1'b0),
    .count(narCount), .rdData(narRdData), .rdValid(narRdValid), .rdFault(narRdFault),
    .capWord(narCap)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [CNT_W-1:0] nextCount(input logic [CNT_W-1:0] cur,
      input logic mc, input logic rt, input logic ds, input logic [STEP_W-1:0] st);
    if (ds) return cur;
    if (!mc) return cur + 1;
    if (rt) return cur + CNT_W'(st);
    return cur;
  endfunction

  // Inputs are already driven; run one edge and check every output.
  task automatic cycle();
    logic [CNT_W-1:0] nxt;
    logic expV, expF;
    string tag;
    nxt  = nextCount(expCount, modeConst, refTick, deepSleep, stepInc);
    expV = rdReq && ctrlWord[2];
    expF = rdReq && !ctrlWord[2];
    if (expV) expRdData = expCount;
    if (deepSleep) tag = "R5";
    else if (modeConst) tag = "R3";
    else if (coreHalt || stopClk) tag = "R4";
    else tag = "R2";
    @(posedge clk);
    @(negedge clk);
    expCount = nxt;
    chk(count == expCount, tag, "count", count, expCount);
    chk(rdValid == expV, expF ? "R8" : "R7", "rdValid", CNT_W'(rdValid), CNT_W'(expV));
    chk(rdFault == expF, "R8", "rdFault", CNT_W'(rdFault), CNT_W'(expF));
    chk(rdData == expRdData, expF ? "R8" : "R7", "rdData", rdData, expRdData);
  endtask

  task automatic drive(input logic mc, input logic rt, input logic [STEP_W-1:0] st,
                       input logic hl, input logic sc, input logic ds,
                       input logic [7:0] cw, input logic rq);
    modeConst = mc; refTick = rt; stepInc = st; coreHalt = hl;
    stopClk = sc; deepSleep = ds; ctrlWord = cw; rdReq = rq;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    bit seen;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk(count == '0, "R1", "count in reset", count, '0);
    chk(!rdValid && !rdFault, "R1", "read flags in reset", CNT_W'({rdValid, rdFault}), '0);
    rstN = 1'b1;
    chk(count == '0, "R1", "count after reset", count, '0);
    // R6: capability word
    chk(capWord == 32'h10, "R6", "capWord", CNT_W'(capWord), 64'h10);

    // R2 with R4: halt and stop-clock asserted, per-cycle mode
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, i[0], 16'hffff, 1'b1, i[1], 1'b0, 8'h04, 1'b0);
      cycle();
    end
    // R3: constant-rate mode with step 7 and a sparse reference
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, (i % 3) == 0, 16'd7, 1'b0, 1'b1, 1'b0, 8'h04, 1'b0);
      cycle();
    end
    // R5: deep sleep in both modes
    for (int i = 0; i < 6; i++) begin
      drive(i[0], 1'b1, 16'd9, 1'b0, 1'b0, 1'b1, 8'h04, 1'b0);
      cycle();
    end
    // R7: back-to-back permitted reads
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b1);
      cycle();
    end
    // R8: refused read with every other control bit set, then idle
    drive(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 8'hfb, 1'b1);
    cycle();
    drive(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 8'hfb, 1'b0);
    cycle();

    // Random mix of modes, sleep, reference pulses and reads
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 4) == 0 ? ~modeConst : modeConst,
            ($urandom % 3) == 0, 16'($urandom),
            1'($urandom), 1'($urandom), ($urandom % 8) == 0,
            8'($urandom), 1'($urandom));
      cycle();
    end

    // R9: wrap of the narrow instance from all ones to zero
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (narCount == '1) seen = 1;
    end
    chk(seen, "R9", "reached all ones", CNT_W'(narCount), CNT_W'({NAR_W{1'b1}}));
    @(negedge clk);
    chk(narCount == '0, "R9", "wrap to zero", CNT_W'(narCount), '0);
    @(negedge clk);
    chk(narCount == NAR_W'(1), "R9", "count after wrap", CNT_W'(narCount), 64'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule